// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block gathers up to forty interrupt lines and folds them onto thirty-two priority levels. Each line has its own five-bit level select. Each line can also be forced active by software. The result is a per-level pending vector, which two enable masks split into a fast class and a normal class. Each class drives its own active-low request to the processor.

The fast class wins in two ways. While it requests, the normal request is held off, and the five-bit vector number names the highest pending fast level. Otherwise the vector number names the highest pending normal level. A valid flag tells a level-0 request apart from no request at all.

Software programs the selects, force bits and masks through a small word-addressed register port with a combinational read. The same port shows the three pending vectors for readback. The parameter `NSRC` sets the number of source lines, from 33 to 40.

Top module: `irq_prio2`

## Requirements
- R1: There are NSRC source inputs, and each has its own 5-bit level select. Level 31 is the highest priority and level 0 the lowest. After reset every select is 0.
- R2: Force bits are OR-ed with the source lines before the level mapping. Offset 1 holds force bits 31:0 in data bits 31:0. Offset 0 holds force bits NSRC-1:32 in data bits NSRC-33:0, and its higher data bits read zero. Clearing a force bit withdraws that request.
- R3: The level-pending vector reads at offset 2. Its bit n is 1 when any effective source whose select is n is active.
- R4: The fast-pending vector reads at offset 4. It equals level-pending AND the fast enable mask, which is at offset 3.
- R5: fast_req_n is 0 exactly when some fast-pending bit is set.
- R6: The normal-pending vector reads at offset 6. It equals level-pending AND the normal enable mask, which is at offset 5. norm_req_n is 0 only when some normal-pending bit is set and no fast-pending bit is set.
- R7: When fast_req_n is 0, vec_num is the index of the highest set fast-pending bit. Otherwise, when norm_req_n is 0, it is the index of the highest set normal-pending bit.
- R8: When neither request is active, both request outputs are 1, vec_num is 0 and vec_valid is 0. vec_valid is 1 whenever either request is 0.
- R9: A source change shows up on the outputs and readbacks after exactly one rising edge. A register write takes effect at its own edge, and the outputs follow one edge later.
- R10: A synchronous reset clears both masks, all force bits and all selects. It also drives both requests to 1.
- R11: The level selects live at offsets 8 to 17. Source 4w+j uses bits 8j+4..8j of offset 8+w. Fields for source indices at or above NSRC read zero, and writes to them are ignored. Offset 7 and offsets above 17 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src | input | NSRC | Interrupt source lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| fast_req_n | output | 1 | Fast interrupt request, active low |
| norm_req_n | output | 1 | Normal interrupt request, active low |
| vec_num | output | 5 | Highest pending level of the winning class |
| vec_valid | output | 1 | A request is active |

## Verification
The embedded properties assume that the source lines and the write port are synchronous to clk and settle before each rising edge. They also assume a fixed NSRC between 33 and 40, so the upper force word always exists. The bench drives every input just after a falling edge and holds it through the next rising edge. It reads registers only while no write is in flight. The bench is built with NSRC set to 38, so the select fields at or above NSRC actually exist and can be checked.

// File: rtl/irq_prio2.sv
module irq_prio2 #(
  parameter int NSRC = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic            reg_wr,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            fast_req_n,
  output logic            norm_req_n,
  output logic [4:0]      vec_num,
  output logic            vec_valid
);
  localparam int NLVL     = 32;
  localparam int LW       = $clog2(NLVL);
  localparam int HI       = NSRC - 32;
  localparam int SEL_BASE = 8;

  logic [NSRC-1:0] frc;
  logic [NLVL-1:0] fen, nen;
  logic [LW-1:0]   sel [NSRC];
  logic [NLVL-1:0] lvl_c, lvl_q, fast_q, norm_q, sel_vec;
  logic [NSRC-1:0] eff;

  function automatic logic [LW-1:0] top_bit(input logic [NLVL-1:0] v);
    top_bit = '0;
    for (int i = 0; i < NLVL; i++)
      if (v[i]) top_bit = i[LW-1:0];
  endfunction

  assign eff = src | frc;

  always_comb begin
    lvl_c = '0;
    for (int i = 0; i < NSRC; i++)
      if (eff[i]) lvl_c[sel[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frc <= '0;
      fen <= '0;
      nen <= '0;
      for (int i = 0; i < NSRC; i++) sel[i] <= '0;
      lvl_q  <= '0;
      fast_q <= '0;
      norm_q <= '0;
      fast_req_n <= 1'b1;
      norm_req_n <= 1'b1;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          5'd0: frc[NSRC-1:32] <= reg_wdata[HI-1:0];
          5'd1: frc[31:0]      <= reg_wdata;
          5'd3: fen            <= reg_wdata;
          5'd5: nen            <= reg_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < NSRC; i++)
        if (reg_wr && reg_addr == 5'(SEL_BASE + i / 4))
          sel[i] <= reg_wdata[8*(i%4) +: LW];
      lvl_q  <= lvl_c;
      fast_q <= lvl_c & fen;
      norm_q <= lvl_c & nen;
      fast_req_n <= ~|(lvl_c & fen);
      norm_req_n <= ~(|(lvl_c & nen) & ~|(lvl_c & fen));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      5'd0: reg_rdata[HI-1:0] = frc[NSRC-1:32];
      5'd1: reg_rdata = frc[31:0];
      5'd2: reg_rdata = lvl_q;
      5'd3: reg_rdata = fen;
      5'd4: reg_rdata = fast_q;
      5'd5: reg_rdata = nen;
      5'd6: reg_rdata = norm_q;
      default: ;
    endcase
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == 5'(SEL_BASE + i / 4))
        reg_rdata[8*(i%4) +: LW] = sel[i];
  end

  assign sel_vec   = !fast_req_n ? fast_q : norm_q;
  assign vec_valid = ~(fast_req_n & norm_req_n);
  assign vec_num   = vec_valid ? top_bit(sel_vec) : '0;

  // R4
  fast_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_q & ~lvl_q) == '0);
  // R5
  fast_req_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_req_n == (|fast_q));
  // R6
  fast_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !norm_req_n |-> (fast_req_n && |norm_q));
  // R7
  vec_top_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ((sel_vec >> vec_num) == 32'd1));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> (vec_num == '0 && fast_q == '0));
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (fast_req_n && norm_req_n && fen == '0 && nen == '0 && frc == '0));
endmodule

// File: tb/sim_irq_prio2.sv
`timescale 1ns/1ps
module sim_irq_prio2;
  localparam int NSRC = 38;
  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fast_req_n, norm_req_n, vec_valid;
  logic [4:0] vec_num;
  int total = 0, bad = 0;

  irq_prio2 #(.NSRC(NSRC)) u0 (.clk, .rst, .src, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .fast_req_n, .norm_req_n, .vec_num, .vec_valid);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic f, input logic n, input logic [4:0] v, input logic ok);
    chk({tag, " fast_req_n"}, 32'(fast_req_n), 32'(f));
    chk({tag, " norm_req_n"}, 32'(norm_req_n), 32'(n));
    chk({tag, " vec_num"}, 32'(vec_num), 32'(v));
    chk({tag, " vec_valid"}, 32'(vec_valid), 32'(ok));
  endtask

  task automatic clean();
    src = '0;
    wr(5'd0, 0); wr(5'd1, 0); wr(5'd3, 0); wr(5'd5, 0);
    for (int w = 8; w < 18; w++) wr(5'(w), 0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    outs("R10 reset", 1, 1, 0, 0);
    rd(5'd8, d);  chk("R1 select reset", d, 0);
    rd(5'd3, d);  chk("R10 fast mask reset", d, 0);
    rd(5'd1, d);  chk("R10 force reset", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(5'd9, 32'd12 << 8);
    wr(5'd5, 32'hFFFF_FFFF);
    settle();
    src[5] = 1'b1; #1;
    chk("R9 no change before edge", 32'(norm_req_n), 1);
    settle();
    rd(5'd2, d); chk("R3 level pending", d, 32'h1 << 12);
    outs("R9 normal after one edge", 1, 0, 12, 1);
  endtask

  task automatic t_fast();
    logic [31:0] d;
    wr(5'd3, 32'h1 << 3);
    wr(5'd8, 32'd3);
    src[0] = 1'b1;
    settle();
    outs("R6 R7 fast wins", 0, 1, 3, 1);
    rd(5'd4, d); chk("R4 fast pending", d, 32'h1 << 3);
    rd(5'd6, d); chk("R6 normal pending", d, (32'h1 << 12) | (32'h1 << 3));
    src[0] = 1'b0;
    settle();
    outs("R5 fast released", 1, 0, 12, 1);
    clean();
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(5'd5, 32'hFFFF_FFFF);
    wr(5'd1, 32'h1 << 20);
    settle();
    outs("R8 level zero valid", 1, 0, 0, 1);
    wr(5'd17, 32'd30 << 8);
    wr(5'd0, 32'h1 << 5);
    settle();
    rd(5'd2, d); chk("R2 forced levels", d, 32'h4000_0001);
    outs("R2 forced high source", 1, 0, 30, 1);
    wr(5'd0, 0); wr(5'd1, 0);
    settle();
    outs("R2 R8 force withdrawn", 1, 1, 0, 0);
    clean();
  endtask

  task automatic t_priority();
    wr(5'd8, (32'd31 << 8) | (32'd17 << 16) | (32'd9 << 24));
    wr(5'd5, 32'h7FFF_FFFF);
    src[1] = 1'b1; src[2] = 1'b1; src[3] = 1'b1;
    settle();
    outs("R7 masked top level", 1, 0, 17, 1);
    wr(5'd5, 32'hFFFF_FFFF);
    settle();
    outs("R1 level 31 highest", 1, 0, 31, 1);
    clean();
  endtask

  task automatic t_unused();
    logic [31:0] d;
    wr(5'd17, 32'hFFFF_FFFF);
    rd(5'd17, d); chk("R11 fields past NSRC", d, 32'h0000_1F1F);
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d); chk("R2 force high width", d, 32'h3F);
    rd(5'd7, d); chk("R11 offset 7 zero", d, 0);
    wr(5'd18, 32'hFFFF_FFFF);
    rd(5'd18, d); chk("R11 offset 18 zero", d, 0);
    clean();
  endtask

  task automatic t_reset2();
    logic [31:0] d;
    wr(5'd3, 32'hFFFF_FFFF); wr(5'd1, 32'h1);
    settle();
    outs("R5 forced fast", 0, 1, 0, 1);
    rst = 1'b1; settle(); rst = 1'b0;
    rd(5'd3, d); chk("R10 fast mask cleared", d, 0);
    rd(5'd1, d); chk("R10 force cleared", d, 0);
    outs("R10 after reset", 1, 1, 0, 0);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_fast();
    t_force();
    t_priority();
    t_unused();
    t_reset2();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule